// File: doc/BRIEF.md
# Phase-Transient Corrector for a Digital PLL Reference Path

This block sits between the reference selector and the phase detector of a digital PLL. When the loop moves to a different reference input, or leaves holdover, the new reference can sit at any phase relative to the loop feedback. Feeding that reference straight to the loop would produce a phase step at the output. To prevent this, the block measures how far the feedback edge leads the next reference edge, in master-clock cycles, and keeps that value. It then delays every later reference edge so that the resulting virtual reference lands on the feedback phase.

All inputs are single-cycle strobes or levels sampled on the master clock. The virtual reference comes out as a one-cycle strobe. The corrected phase error comes out as a signed word, qualified by `err_valid`. The loop filter takes every sample, so this output has no back-pressure: each `err_valid` pulse is a new word, and `phase_err` holds its value between pulses. A re-measurement after holdover only happens when `hold_remeasure` is high. A plain reference switch always triggers one.

Top module: `tie_corrector`

## Requirements
- R1: Reset values: `vref_strobe`, `err_valid` and `phase_err` are 0, and the stored offset is 0. With a zero offset, a reference edge in cycle b produces a virtual strobe in cycle b+REF_PERIOD, so the strobe keeps the phase of the reference.
- R2: A `ref_switch` pulse starts a measurement. The stored offset becomes the number of cycles from the first feedback edge after the trigger cycle to the next reference edge after that, taken modulo REF_PERIOD. A reference edge in the same cycle as that feedback edge does not count.
- R3: A `hold_exit` pulse starts a measurement only while `hold_remeasure` is 1. While `hold_remeasure` is 0, `hold_exit` leaves the stored offset and the virtual reference unchanged.
- R4: For a reference edge in cycle b and stored offset o, `vref_strobe` is high for one cycle in cycle b+REF_PERIOD-o. Every reference edge reloads the delay.
- R5: For a feedback edge in cycle c outside a measurement, `err_valid` is 1 in cycle c+1. In that cycle `phase_err` is the signed two's-complement distance from the latest virtual strobe to c, wrapped into (-REF_PERIOD/2, REF_PERIOD/2]. A positive value means the feedback lags.
- R6: From the cycle after a trigger until the cycle after the offset capture, `err_valid` is 0 and `phase_err` is 0.
- R7: The stored offset persists until the next trigger. `offset_clr` sets it to 0 and abandons any measurement. `offset_clr` wins over a trigger in the same cycle.
- R8: A trigger during an unfinished measurement restarts it, and any feedback edge seen before the new trigger is discarded.
- R9: When reference and feedback are periodic with period REF_PERIOD, after a capture the virtual strobe falls in the same cycle as each feedback edge, and `phase_err` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | Selected-reference edge strobe |
| fb_edge | input | 1 | Loop feedback edge strobe |
| ref_switch | input | 1 | Pulse: active reference input changed |
| hold_exit | input | 1 | Pulse: loop leaves holdover for normal mode |
| hold_remeasure | input | 1 | Mode level: re-measure on holdover exit |
| offset_clr | input | 1 | Synchronous clear of the stored offset |
| vref_strobe | output | 1 | Virtual reference edge strobe |
| err_valid | output | 1 | Qualifies a new `phase_err` word |
| phase_err | output | $clog2(REF_PERIOD)+1 | Signed corrected phase error in cycles |

## Verification
The hardest situation to reach is a new trigger that arrives after a measurement has seen its feedback edge but before the closing reference edge. The bench reaches it by watching for the feedback phase, pulsing a second switch in the next cycle and moving the feedback phase at the same moment. A discarded edge then produces a visibly wrong virtual phase. Every pair of reference and feedback phases is swept. After each capture the feedback phase is shifted, so that the signed wrap of the error is seen at every distance.

// File: rtl/tie_pkg.sv
package tie_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_ARM   = 2'd1,
    MS_COUNT = 2'd2
  } meas_state_e;
endpackage

// File: rtl/tie_meas.sv
module tie_meas
  import tie_pkg::*;
#(
  parameter int P  = 8,
  parameter int CW = $clog2(P)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_edge,
  input  logic          fb_edge,
  input  logic          trig,
  input  logic          clr,
  output logic [CW-1:0] offset,
  output logic          busy
);
  localparam logic [CW-1:0] LAST = CW'(P - 1);

  meas_state_e   state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= MS_IDLE;
      cnt    <= '0;
      offset <= '0;
    end else if (clr) begin
      state  <= MS_IDLE;
      cnt    <= '0;
      offset <= '0;
    end else if (trig) begin
      state <= MS_ARM;
      cnt   <= '0;
    end else begin
      case (state)
        MS_ARM: begin
          if (fb_edge) begin
            state <= MS_COUNT;
            cnt   <= CW'(1);
          end
        end
        MS_COUNT: begin
          if (ref_edge) begin
            offset <= cnt;
            state  <= MS_IDLE;
          end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
          end
        end
        default: state <= MS_IDLE;
      endcase
    end
  end

  assign busy = (state != MS_IDLE) || trig;
endmodule

// File: rtl/tie_vref_gen.sv
module tie_vref_gen #(
  parameter int P  = 8,
  parameter int CW = $clog2(P)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_edge,
  input  logic [CW-1:0] offset,
  output logic          vref
);
  logic [CW-1:0] delay;
  logic [CW-1:0] dcnt;
  logic          pend;

  assign delay = CW'(P - 1) - offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      dcnt <= '0;
      vref <= 1'b0;
    end else if (ref_edge) begin
      pend <= (delay != '0);
      dcnt <= delay;
      vref <= (delay == '0);
    end else begin
      vref <= pend && (dcnt == CW'(1));
      if (pend) begin
        dcnt <= dcnt - CW'(1);
        if (dcnt == CW'(1)) pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tie_phase_det.sv
module tie_phase_det #(
  parameter int P  = 8,
  parameter int CW = $clog2(P),
  parameter int EW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vref,
  input  logic          fb_edge,
  input  logic          busy,
  output logic          err_valid,
  output logic [EW-1:0] phase_err
);
  logic [CW-1:0] vcnt;
  logic [CW-1:0] since;
  logic [EW-1:0] ext;
  logic [EW-1:0] wrapped;

  assign since   = vref ? '0 : vcnt;
  assign ext     = {1'b0, since};
  assign wrapped = (since > CW'(P / 2)) ? ext - EW'(P) : ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcnt <= '0;
    end else if (vref) begin
      vcnt <= CW'(1);
    end else begin
      vcnt <= (vcnt == CW'(P - 1)) ? '0 : vcnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      phase_err <= '0;
    end else if (busy) begin
      err_valid <= 1'b0;
      phase_err <= '0;
    end else begin
      err_valid <= fb_edge;
      if (fb_edge) phase_err <= wrapped;
    end
  end
endmodule

// File: rtl/tie_corrector.sv
module tie_corrector #(
  parameter  int REF_PERIOD = 8,
  localparam int CW         = $clog2(REF_PERIOD),
  localparam int EW         = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_edge,
  input  logic          fb_edge,
  input  logic          ref_switch,
  input  logic          hold_exit,
  input  logic          hold_remeasure,
  input  logic          offset_clr,
  output logic          vref_strobe,
  output logic          err_valid,
  output logic [EW-1:0] phase_err
);
  logic          trig;
  logic          meas_busy;
  logic [CW-1:0] offset_q;

  assign trig = ref_switch | (hold_exit & hold_remeasure);

  tie_meas #(.P(REF_PERIOD), .CW(CW)) u_meas (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_edge(ref_edge),
    .fb_edge (fb_edge),
    .trig    (trig),
    .clr     (offset_clr),
    .offset  (offset_q),
    .busy    (meas_busy)
  );

  tie_vref_gen #(.P(REF_PERIOD), .CW(CW)) u_vref (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_edge(ref_edge),
    .offset  (offset_q),
    .vref    (vref_strobe)
  );

  tie_phase_det #(.P(REF_PERIOD), .CW(CW), .EW(EW)) u_pdet (
    .clk      (clk),
    .rst_n    (rst_n),
    .vref     (vref_strobe),
    .fb_edge  (fb_edge),
    .busy     (meas_busy),
    .err_valid(err_valid),
    .phase_err(phase_err)
  );
endmodule

// File: rtl/tie_corrector_chk.sv
module tie_corrector_chk #(
  parameter int CW = 3,
  parameter int EW = CW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fb_edge,
  input logic          ref_switch,
  input logic          hold_exit,
  input logic          hold_remeasure,
  input logic          offset_clr,
  input logic          busy,
  input logic [CW-1:0] offset,
  input logic          err_valid,
  input logic [EW-1:0] phase_err
);
  // R2
  switch_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_switch && !offset_clr) |=> busy);

  // R3
  hold_remeasure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_exit && hold_remeasure && !offset_clr) |=> busy);

  // R5
  valid_follows_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(fb_edge));

  // R6
  quiet_in_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!err_valid && phase_err == '0));

  // R7
  offset_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !offset_clr) |=> $stable(offset));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset_clr |=> (offset == '0 && !busy));
endmodule

bind tie_corrector tie_corrector_chk #(.CW(CW), .EW(EW)) u_tie_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fb_edge       (fb_edge),
  .ref_switch    (ref_switch),
  .hold_exit     (hold_exit),
  .hold_remeasure(hold_remeasure),
  .offset_clr    (offset_clr),
  .busy          (meas_busy),
  .offset        (offset_q),
  .err_valid     (err_valid),
  .phase_err     (phase_err)
);

// File: tb/test_tie_corrector.sv
module test_tie_corrector;
  localparam int P  = 8;
  localparam int EW = $clog2(P) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_edge = 1'b0, fb_edge = 1'b0;
  logic ref_switch = 1'b0, hold_exit = 1'b0, hold_remeasure = 1'b0, offset_clr = 1'b0;
  logic vref_strobe, err_valid;
  logic [EW-1:0] phase_err;

  int k = 0;
  int rph = 0;
  int fph = 0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tie_corrector #(.REF_PERIOD(P)) i_tie_corrector (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .ref_switch(ref_switch), .hold_exit(hold_exit), .hold_remeasure(hold_remeasure),
    .offset_clr(offset_clr), .vref_strobe(vref_strobe), .err_valid(err_valid),
    .phase_err(phase_err)
  );

  function automatic int wrapd(int x);
    int d = ((x % P) + P) % P;
    if (d > P / 2) d = d - P;
    return d;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s slot %0d: actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  task automatic tick();
    ref_edge = ((k % P) == rph);
    fb_edge  = ((k % P) == fph);
    @(posedge clk);
    k++;
    @(negedge clk);
    ref_switch = 1'b0; hold_exit = 1'b0; offset_clr = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // virtual strobe expected at phase vph; error words relative to vph
  task automatic check_phase(string req, int vph, int n);
    for (int i = 0; i < n; i++) begin
      chk(req, int'(vref_strobe), int'((k % P) == vph));
      chk(req, int'(err_valid), int'(((k - 1) % P) == fph));
      if (((k - 1) % P) == fph)
        chk(req, int'($signed(phase_err)), wrapd(fph - vph));
      tick();
    end
  endtask

  task automatic measure_and_check_quiet();
    int k0, f1, b;
    k0 = k;
    ref_switch = 1'b1;
    tick();
    f1 = k0 + 1;
    while ((f1 % P) != fph) f1++;
    b = f1 + 1;
    while ((b % P) != rph) b++;
    while (k <= b + 1) begin
      chk("R6", int'(err_valid), 0);
      chk("R6", int'(phase_err), 0);
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fold, s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(vref_strobe), 0);
    chk("R1", int'(err_valid), 0);
    chk("R1", int'(phase_err), 0);
    rst_n = 1'b1;
    // R1: zero offset keeps the reference phase
    rph = 3; fph = 6;
    run(2 * P);
    check_phase("R1", rph, 2 * P);

    for (int r = 0; r < P; r++) begin
      for (int f = 0; f < P; f++) begin
        rph = r; fph = f;
        run(P);
        measure_and_check_quiet();           // R2, R6
        run(2 * P);
        check_phase("R9", fph, 2 * P);       // R2, R4, R9
        fold = fph;
        s = (r * 3 + f + 1) % P;
        fph = (fph + s) % P;
        run(P + 1);
        check_phase("R5", fold, 2 * P);      // R5 signed wrap
        hold_exit = 1'b1; hold_remeasure = 1'b0;
        tick();
        run(2 * P);
        check_phase("R3", fold, P);          // R3 no capture, R7 persists
        offset_clr = 1'b1; ref_switch = 1'b1;
        tick();
        for (int i = 0; i < P; i++) begin    // R7 clear wins, no busy
          chk("R7", int'(err_valid), int'(((k - 1) % P) == fph));
          tick();
        end
        run(P);
        check_phase("R7", rph, P);
        hold_exit = 1'b1; hold_remeasure = 1'b1;
        tick();
        run(3 * P);
        check_phase("R3", fph, P);
      end
    end

    // R8: restart after the feedback edge was already seen
    rph = 0; fph = 1;
    run(P);
    ref_switch = 1'b1;
    tick();
    while (((k - 1) % P) != 1) tick();
    fph = 5;
    ref_switch = 1'b1;
    tick();
    run(3 * P);
    check_phase("R8", 5, 2 * P);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule